// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

This block sits at the front of a short in-order pipeline and decides the next fetch address. It owns the fetch program counter and a small direct-mapped table of conditional branches. Each table slot holds the fall-through address of a branch (its pc+4), the branch target and a valid flag. Every cycle the block looks up the current pc+4. A hit predicts the branch taken and sends the stored target to the pc. A miss predicts not taken and sends pc+4. The hit flag is the whole prediction. The pipeline carries it beside the instruction and returns it at execute.

At execute the pipeline returns the predicted flag, the real outcome, the branch's pc+4, its target and the epoch the instruction was fetched under. If the two flags differ, the block redirects the pc and bumps the epoch, so younger wrong-path work can be dropped. When the miss was really a taken branch, it also records the branch in the table. When a predicted-taken branch falls through, the block only redirects and leaves the table alone. A resolution that carries an epoch other than the current one comes from the wrong path and is ignored.

Top module: `btb_predictor`

## Requirements
- R1: After reset the fetch pc equals RESET_PC (default 0), the epoch is 0 and every table slot is invalid, so no lookup hits.
- R2: With fetchEn high, no redirect and a lookup miss, the pc advances to pc+4 on the next clock.
- R3: A lookup hits only when the slot it selects is valid and its stored pc+4 equals the current pc+4 in full. On a hit with fetchEn high and no redirect, the stored target becomes the pc on the next clock. A later write to the same slot replaces the earlier branch.
- R4: The slot index is bits [IDX_W+1:2] of pc+4 (bits [4:2] for 8 slots), not bits of pc. Two branches whose pc+4 values share these bits compete for one slot.
- R5: A misprediction is flagged only by the predicted-taken bit differing from the actual outcome. A predicted-taken branch that is taken never redirects, whatever target it reports.
- R6: Predicted not taken but taken: mispredict is high, the pc becomes exTarget on the next clock, and (exPcPlus4, exTarget) is written into the slot selected by exPcPlus4.
- R7: Predicted taken but not taken: mispredict is high, the pc becomes exPcPlus4 on the next clock, and the table is not modified.
- R8: Each misprediction increments the EP_W-bit epoch by one, modulo 2^EP_W (default 2 bits, 3 wraps to 0). Otherwise the epoch holds.
- R9: A resolution whose exEpoch differs from the current epoch has no effect: no mispredict, no table write, no epoch change.
- R10: A redirect takes priority over fetch advance. With fetchEn low and no redirect, the pc holds.
- R11: A table write and a lookup of the same slot in the same cycle: the lookup sees the contents before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchEn | input | 1 | Fetch stage accepts the current pc and may advance |
| fetchPc | output | PC_W | Current fetch pc |
| fetchHit | output | 1 | Lookup of current pc+4 hit (predicted taken) |
| fetchEpoch | output | EP_W | Epoch to tag the current fetch with |
| exValid | input | 1 | A conditional branch resolves at execute this cycle |
| exPredTaken | input | 1 | Hit bit carried with the resolving branch |
| exTaken | input | 1 | Actual branch outcome |
| exEpoch | input | EP_W | Epoch the resolving branch was fetched under |
| exPcPlus4 | input | PC_W | pc+4 of the resolving branch |
| exTarget | input | PC_W | Target of the resolving branch |
| mispredict | output | 1 | Resolution redirects this cycle |

## Verification
The hardest conditions to reach are two cases. In one, a trained branch must be fetched again after a redirect. In the other, a second branch must land in an occupied slot with a different pc+4. Neither comes from straight-line fetch alone. The stimulus uses deliberate predicted-taken-but-not-taken resolutions as a steering tool: each one sends the pc to any chosen fall-through address without touching the table. This lets the bench revisit 0x10 after training, land on the aliasing address 0x30, and overwrite slot 5. The same steering also walks the epoch through its wrap. Stale-epoch resolutions are mixed in between to show they change nothing.

// File: rtl/btb_pkg.sv
package btb_pkg;
  // Strobes from control to datapath, one per action in a cycle
  typedef struct packed {
    logic redirect;   // load pc from execute, bump epoch
    logic toTarget;   // redirect goes to branch target (else fall-through)
    logic tblWrite;   // record branch in table
    logic advance;    // normal fetch progression
  } ctl_t;
endpackage

// File: rtl/btb_control.sv
module btb_control #(
  parameter int EP_W = 2
) (
  input  logic            fetchEn,
  input  logic            exValid,
  input  logic            exPredTaken,
  input  logic            exTaken,
  input  logic [EP_W-1:0] exEpoch,
  input  logic [EP_W-1:0] curEpoch,
  output btb_pkg::ctl_t   ctl
);
  logic liveRes;
  logic wrongDir;

  always_comb begin
    liveRes      = exValid && (exEpoch == curEpoch);
    wrongDir     = liveRes && (exPredTaken != exTaken);
    ctl.redirect = wrongDir;
    ctl.toTarget = wrongDir && exTaken;
    ctl.tblWrite = wrongDir && exTaken;
    ctl.advance  = fetchEn && !wrongDir;
  end
endmodule

// File: rtl/btb_datapath.sv
module btb_datapath #(
  parameter int              PC_W     = 32,
  parameter int              ENTRIES  = 8,
  parameter int              EP_W     = 2,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rstN,
  input  btb_pkg::ctl_t   ctl,
  input  logic [PC_W-1:0] exPcPlus4,
  input  logic [PC_W-1:0] exTarget,
  output logic [PC_W-1:0] pcQ,
  output logic            lookupHit,
  output logic [EP_W-1:0] epochQ
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic [ENTRIES-1:0] validQ;
  logic [PC_W-1:0]    tagQ [ENTRIES];
  logic [PC_W-1:0]    tgtQ [ENTRIES];

  logic [PC_W-1:0]  lkPc4;
  logic [IDX_W-1:0] lkIdx;
  logic [IDX_W-1:0] wrIdx;
  logic [PC_W-1:0]  pcNext;

  always_comb begin
    lkPc4     = pcQ + STEP;
    lkIdx     = lkPc4[IDX_W+1:2];
    wrIdx     = exPcPlus4[IDX_W+1:2];
    lookupHit = validQ[lkIdx] && (tagQ[lkIdx] == lkPc4);
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN)
        validQ[g] <= 1'b0;
      else if (ctl.tblWrite && (wrIdx == IDX_W'(g)))
        validQ[g] <= 1'b1;
    end
    always_ff @(posedge clk) begin
      if (ctl.tblWrite && (wrIdx == IDX_W'(g))) begin
        tagQ[g] <= exPcPlus4;
        tgtQ[g] <= exTarget;
      end
    end
  end

  always_comb begin
    if (ctl.redirect)
      pcNext = ctl.toTarget ? exTarget : exPcPlus4;
    else if (ctl.advance)
      pcNext = lookupHit ? tgtQ[lkIdx] : lkPc4;
    else
      pcNext = pcQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ    <= RESET_PC;
      epochQ <= '0;
    end else begin
      pcQ <= pcNext;
      if (ctl.redirect)
        epochQ <= epochQ + EP_W'(1);
    end
  end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int              PC_W     = 32,
  parameter int              ENTRIES  = 8,
  parameter int              EP_W     = 2,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            fetchEn,
  output logic [PC_W-1:0] fetchPc,
  output logic            fetchHit,
  output logic [EP_W-1:0] fetchEpoch,
  input  logic            exValid,
  input  logic            exPredTaken,
  input  logic            exTaken,
  input  logic [EP_W-1:0] exEpoch,
  input  logic [PC_W-1:0] exPcPlus4,
  input  logic [PC_W-1:0] exTarget,
  output logic            mispredict
);
  btb_pkg::ctl_t ctl;

  btb_control #(.EP_W(EP_W)) uCtl (
    .fetchEn    (fetchEn),
    .exValid    (exValid),
    .exPredTaken(exPredTaken),
    .exTaken    (exTaken),
    .exEpoch    (exEpoch),
    .curEpoch   (fetchEpoch),
    .ctl        (ctl)
  );

  btb_datapath #(
    .PC_W(PC_W), .ENTRIES(ENTRIES), .EP_W(EP_W), .RESET_PC(RESET_PC)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .exPcPlus4(exPcPlus4),
    .exTarget (exTarget),
    .pcQ      (fetchPc),
    .lookupHit(fetchHit),
    .epochQ   (fetchEpoch)
  );

  assign mispredict = ctl.redirect;
endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
  parameter int PC_W = 32,
  parameter int EP_W = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic            fetchEn,
  input logic [PC_W-1:0] fetchPc,
  input logic            fetchHit,
  input logic [EP_W-1:0] fetchEpoch,
  input logic            exValid,
  input logic            exTaken,
  input logic [EP_W-1:0] exEpoch,
  input logic [PC_W-1:0] exPcPlus4,
  input logic [PC_W-1:0] exTarget,
  input logic            mispredict
);
  assert_miss_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    fetchEn && !fetchHit && !mispredict |=> fetchPc == $past(fetchPc) + PC_W'(4));

  assert_taken_fix_R6: assert property (@(posedge clk) disable iff (!rstN)
    mispredict && exTaken |=> fetchPc == $past(exTarget));

  assert_fallthru_fix_R7: assert property (@(posedge clk) disable iff (!rstN)
    mispredict && !exTaken |=> fetchPc == $past(exPcPlus4));

  assert_epoch_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    mispredict |=> fetchEpoch == $past(fetchEpoch) + EP_W'(1));

  assert_epoch_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !mispredict |=> $stable(fetchEpoch));

  assert_stale_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    exValid && (exEpoch != fetchEpoch) |-> !mispredict);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !fetchEn && !mispredict |=> $stable(fetchPc));
endmodule

bind btb_predictor btb_predictor_chk #(.PC_W(PC_W), .EP_W(EP_W)) uChk (
  .clk(clk), .rstN(rstN), .fetchEn(fetchEn), .fetchPc(fetchPc),
  .fetchHit(fetchHit), .fetchEpoch(fetchEpoch), .exValid(exValid),
  .exTaken(exTaken), .exEpoch(exEpoch), .exPcPlus4(exPcPlus4),
  .exTarget(exTarget), .mispredict(mispredict)
);

// File: tb/tb_btb_predictor.sv
module tb_btb_predictor;
  localparam int PC_W = 32;
  localparam int EP_W = 2;
  localparam int ENTRIES = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rstN, fetchEn, fetchHit, exValid, exPredTaken, exTaken, mispredict;
  logic [PC_W-1:0] fetchPc, exPcPlus4, exTarget;
  logic [EP_W-1:0] fetchEpoch, exEpoch;

  btb_predictor #(.PC_W(PC_W), .ENTRIES(ENTRIES), .EP_W(EP_W)) dut (
    .clk(clk), .rstN(rstN), .fetchEn(fetchEn), .fetchPc(fetchPc),
    .fetchHit(fetchHit), .fetchEpoch(fetchEpoch), .exValid(exValid),
    .exPredTaken(exPredTaken), .exTaken(exTaken), .exEpoch(exEpoch),
    .exPcPlus4(exPcPlus4), .exTarget(exTarget), .mispredict(mispredict)
  );

  typedef struct {
    logic [PC_W-1:0] pc;
    logic [EP_W-1:0] ep;
    string           tag;
  } exp_t;
  exp_t expQ[$];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference state built from the requirements
  logic            mVal [ENTRIES];
  logic [PC_W-1:0] mTag [ENTRIES];
  logic [PC_W-1:0] mTgt [ENTRIES];
  logic [PC_W-1:0] mPc;
  logic [EP_W-1:0] mEp;

  task automatic check(string tag, string what, logic [PC_W-1:0] act, logic [PC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Monitor: compares registered state after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        check(e.tag, "pc", fetchPc, e.pc);
        check(e.tag, "epoch", PC_W'(fetchEpoch), PC_W'(e.ep));
      end
    end
  end

  // Driver: one cycle of stimulus, combinational checks, expected push
  task automatic step(string tag, bit fe, bit ev, bit stale, bit pred, bit tk,
                      logic [PC_W-1:0] p4, logic [PC_W-1:0] tgt);
    logic [PC_W-1:0] lk4;
    logic [2:0]      idx, widx;
    bit              hit, mis;
    exp_t            e;
    @(negedge clk);
    fetchEn = fe; exValid = ev; exPredTaken = pred; exTaken = tk;
    exPcPlus4 = p4; exTarget = tgt;
    exEpoch = stale ? mEp - EP_W'(1) : mEp;
    #1;
    lk4 = mPc + 4;
    idx = lk4[4:2];
    hit = mVal[idx] && (mTag[idx] == lk4);
    mis = ev && !stale && (pred != tk);
    check(tag, "fetchHit", PC_W'(fetchHit), PC_W'(hit));
    check(tag, "mispredict", PC_W'(mispredict), PC_W'(mis));
    if (mis) begin
      mPc = tk ? tgt : p4;
      mEp = mEp + EP_W'(1);
      if (tk) begin
        widx = p4[4:2];
        mVal[widx] = 1'b1; mTag[widx] = p4; mTgt[widx] = tgt;
      end
    end else if (fe) begin
      mPc = hit ? mTgt[idx] : lk4;
    end
    e.pc = mPc; e.ep = mEp; e.tag = tag;
    expQ.push_back(e);
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 0; fetchEn = 0; exValid = 0; exPredTaken = 0; exTaken = 0;
    exEpoch = '0; exPcPlus4 = '0; exTarget = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      mVal[i] = 0; mTag[i] = '0; mTgt[i] = '0;
    end
    mPc = '0; mEp = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    #1;
    check("R1", "pc", fetchPc, '0);
    check("R1", "epoch", PC_W'(fetchEpoch), '0);
    check("R1", "fetchHit", PC_W'(fetchHit), '0);

    step("R2 seq", 1, 0, 0, 0, 0, '0, '0);
    step("R2 seq", 1, 0, 0, 0, 0, '0, '0);
    step("R2 seq", 1, 0, 0, 0, 0, '0, '0);
    step("R2 seq", 1, 0, 0, 0, 0, '0, '0);
    // pc=0x10: train slot 5 while it is looked up (R11 old contents), R6 redirect
    step("R6 R11 train", 1, 1, 0, 0, 1, 32'h14, 32'h100);
    step("R10 hold", 0, 0, 0, 0, 0, '0, '0);
    step("R7 steer", 1, 1, 0, 1, 0, 32'h10, 32'h0);
    step("R3 hit", 1, 0, 0, 0, 0, '0, '0);
    step("R9 stale", 1, 1, 1, 0, 1, 32'h24, 32'h300);
    step("R5 target unchecked", 1, 1, 0, 1, 1, 32'h14, 32'h999);
    step("R7 R8 steer", 1, 1, 0, 1, 0, 32'h30, 32'h0);
    step("R4 alias miss", 1, 0, 0, 0, 0, '0, '0);
    step("R8 wrap", 1, 1, 0, 1, 0, 32'h10, 32'h0);
    step("R7 table kept", 1, 0, 0, 0, 0, '0, '0);
    step("R3 R10 overwrite", 0, 1, 0, 0, 1, 32'h34, 32'h200);
    step("R7 steer", 1, 1, 0, 1, 0, 32'h10, 32'h0);
    step("R3 replaced miss", 1, 0, 0, 0, 0, '0, '0);
    step("R7 steer", 1, 1, 0, 1, 0, 32'h30, 32'h0);
    step("R3 new hit", 1, 0, 0, 0, 0, '0, '0);
    step("R4 train pc4 idx", 1, 1, 0, 0, 1, 32'h20, 32'h400);
    step("R7 steer", 1, 1, 0, 1, 0, 32'h1c, 32'h0);
    step("R4 pc4 index hit", 1, 0, 0, 0, 0, '0, '0);
    step("R9 stale taken", 1, 1, 1, 1, 0, 32'h50, 32'h0);
    step("R2 idle tail", 1, 0, 0, 0, 0, '0, '0);

    repeat (2) @(posedge clk);
    #3;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule